// File: doc/BRIEF.md
# Packet Capture Record Formatter

This block sits behind a capture interface of a network monitoring chip. It takes one received Ethernet frame at a time as a byte stream and emits one capture record per frame as a stream of 64-bit words toward a host buffer. Each record starts with a 16-byte header. After the header come a zero offset byte and a zero pad byte, so the IP header of the frame lands on a 32-bit boundary. The captured frame bytes follow, then zero fill up to an 8-byte multiple. The header carries the arrival timestamp sampled on the first byte of the frame, the interface number, the capture flags, the record length, a count of frames lost, and the full wire length.

Capture is limited by a programmable snap length. In variable-length mode a short frame gives a short record. In fixed-length mode every record has the length of a full snapped frame, and the space behind a short frame is zero. The frame is stored internally until its end marker arrives, because the header depends on the final length. While a finished record is waiting for or draining into the output, a frame that starts is discarded whole and counted. The count goes into the next record that is written.

Top module: `caprec_formatter`

## Requirements
- R1: The snap length in effect for a frame is the `snapLen` value seen on its first byte, raised to 32 if smaller, lowered to 9600 if larger, then rounded down to a multiple of 8.
- R2: In variable-length mode (`varMode`=1) the record length is the captured byte count plus 18, rounded up to a multiple of 8. The captured byte count is the smaller of the frame length and the snap length.
- R3: In fixed-length mode (`varMode`=0) the record length is the snap length plus 24, whatever the frame length.
- R4: A record is record-length/8 words long, and `outLast` is high on its final word only.
- R5: Record byte n is carried on `outData[63-8n%64 -: 8]` of word n/8, so the first byte is the most significant. Word 0 holds the 64-bit timestamp sampled on the first byte of the frame, least significant byte first.
- R6: Record bytes 8 to 15 hold the following fields: type = 2, flags, record length (16-bit, big-endian), loss count (16-bit, big-endian) and wire length (16-bit, big-endian).
- R7: Flags bits 1:0 give the interface number sampled on the first byte. Bit 2 is set in variable-length mode, bit 3 when the frame was longer than the snap length, and bit 4 when `inErr` was high on any byte of the frame. Bits 7:5 are zero.
- R8: Record bytes 16 and 17 are zero. Frame byte i is record byte 18+i for every captured byte, and every byte after the captured data is zero.
- R9: A frame whose first byte arrives while a record is being output produces no record, and none of its bytes appears in any record. A frame that starts while the block is idle is recorded in full, up to the snap length.
- R10: The loss field reports the number of frames discarded since the previous record was committed. The count saturates at 0xFFFF and restarts from zero once it has been placed in a record.
- R11: The wire length field holds the full received frame length, also when the record is truncated.
- R12: `outValid` is low after reset. Once `outValid` is high, `outData` and `outLast` hold steady until `outReady` accepts the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A frame byte is present |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | First byte of a frame |
| inEof | input | 1 | Last byte of a frame |
| inErr | input | 1 | Receive error seen on this byte |
| inIface | input | 2 | Capture interface number, sampled on the first byte |
| inStamp | input | 64 | Arrival timestamp, sampled on the first byte |
| snapLen | input | SNAP_W | Programmed snap length in bytes |
| varMode | input | 1 | 1 = variable-length records, 0 = fixed-length records |
| outData | output | 64 | Record word |
| outValid | output | 1 | Record word is present |
| outReady | input | 1 | Downstream accepts the word |
| outLast | output | 1 | Final word of the record |

## Verification
The bench targets the snap-length edges. These include a frame exactly at the snap length, values below the minimum, above the maximum and not a multiple of 8, and a one-byte frame. A wrong clamp or rounding would show up as a wrong record length and a wrong truncation flag, or as a record missing its tail. Frames are started while a record is stalled on `outReady`, including a long run that pushes the loss count to saturation. A design that cut records short, let bytes of a dropped frame leak in, reported the loss in the wrong record or let the count wrap would fail the whole-record comparison. Each word of every record is compared, so wrong fill bytes, a wrong timestamp byte order or a header field with swapped bytes would also be caught.

// File: rtl/caprec_pkg.sv
package caprec_pkg;

  localparam int HDR_BYTES  = 16;
  localparam int DATA_OFS   = 18;
  localparam int FIX_EXTRA  = 24;
  localparam logic [7:0] REC_TYPE_ETH = 8'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPT,
    ST_EMIT
  } fmtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic frameStart;
    logic byteStore;
    logic recCommit;
  } ctlStrobe_t;

  function automatic logic [15:0] satInc16(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  function automatic logic [15:0] roundUp8(input logic [15:0] v);
    return (v + 16'd7) & 16'hFFF8;
  endfunction

endpackage

// File: rtl/caprec_ctrl.sv
module caprec_ctrl
  import caprec_pkg::*;
#(
  parameter int MIN_SNAP = 32,
  parameter int MAX_SNAP = 9600,
  parameter int SNAP_W   = 14,
  parameter int ADDR_W   = 14,
  parameter int IDX_W    = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic              inErr,
  input  logic [SNAP_W-1:0] snapLen,
  input  logic              varMode,
  input  logic              outReady,
  output ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [IDX_W-1:0]  emitIdx,
  output logic [15:0]       cmtRecLen,
  output logic [15:0]       cmtWireLen,
  output logic [15:0]       cmtLoss,
  output logic [15:0]       cmtCapEnd,
  output logic              cmtTrunc,
  output logic              cmtErr,
  output logic              outValid,
  output logic              outLast
);

  fmtState_t        state;
  logic [15:0]      snapReg;
  logic             modeReg;
  logic [15:0]      byteCnt;
  logic             errAcc;
  logic [15:0]      lossCnt;
  logic [IDX_W-1:0] lastIdx;

  logic             startHit, dataHit, endHit, dropHit;
  logic [15:0]      snapNow, posNow, lenNow, capNow, recLenNow;
  logic             modeNow;
  logic [IDX_W-1:0] idxNow;

  function automatic logic [15:0] clampSnap(input logic [SNAP_W-1:0] v);
    logic [15:0] w;
    w = 16'(v);
    if (w < 16'(MIN_SNAP))      w = 16'(MIN_SNAP);
    else if (w > 16'(MAX_SNAP)) w = 16'(MAX_SNAP);
    return w & 16'hFFF8;
  endfunction

  always_comb begin
    startHit  = inValid && inSof && (state == ST_IDLE);
    dataHit   = inValid && (state == ST_CAPT);
    dropHit   = inValid && inSof && (state == ST_EMIT);
    endHit    = (startHit || dataHit) && inEof;
    snapNow   = (state == ST_IDLE) ? clampSnap(snapLen) : snapReg;
    modeNow   = (state == ST_IDLE) ? varMode : modeReg;
    posNow    = (state == ST_IDLE) ? 16'd0 : byteCnt;
    lenNow    = satInc16(posNow);
    capNow    = (lenNow > snapNow) ? snapNow : lenNow;
    recLenNow = modeNow ? roundUp8(capNow + 16'(DATA_OFS))
                        : snapNow + 16'(FIX_EXTRA);
    idxNow    = IDX_W'(recLenNow[15:3] - 13'd1);
  end

  always_comb begin
    strobe.frameStart = startHit;
    strobe.byteStore  = (startHit || dataHit) && (posNow < snapNow);
    strobe.recCommit  = endHit;
    wrAddr     = ADDR_W'(posNow + 16'(DATA_OFS));
    cmtRecLen  = recLenNow;
    cmtWireLen = lenNow;
    cmtLoss    = lossCnt;
    cmtCapEnd  = capNow + 16'(DATA_OFS);
    cmtTrunc   = lenNow > snapNow;
    cmtErr     = ((state == ST_CAPT) && errAcc) || inErr;
    outValid   = (state == ST_EMIT);
    outLast    = (state == ST_EMIT) && (emitIdx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      snapReg <= '0;
      modeReg <= 1'b0;
      byteCnt <= '0;
      errAcc  <= 1'b0;
      emitIdx <= '0;
      lastIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startHit) begin
            snapReg <= snapNow;
            modeReg <= varMode;
            byteCnt <= lenNow;
            errAcc  <= inErr;
            if (inEof) begin
              state   <= ST_EMIT;
              emitIdx <= '0;
              lastIdx <= idxNow;
            end else begin
              state <= ST_CAPT;
            end
          end
        end
        ST_CAPT: begin
          if (dataHit) begin
            byteCnt <= lenNow;
            errAcc  <= errAcc | inErr;
            if (inEof) begin
              state   <= ST_EMIT;
              emitIdx <= '0;
              lastIdx <= idxNow;
            end
          end
        end
        ST_EMIT: begin
          if (outReady) begin
            if (emitIdx == lastIdx) state <= ST_IDLE;
            else emitIdx <= emitIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // loss count: cleared when handed to a committed record, saturating otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lossCnt <= '0;
    else if (endHit)  lossCnt <= '0;
    else if (dropHit) lossCnt <= satInc16(lossCnt);
  end

endmodule

// File: rtl/caprec_datapath.sv
module caprec_datapath
  import caprec_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int IDX_W  = 11,
  parameter int WORDS  = 1203
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrByte,
  input  logic [63:0]       inStamp,
  input  logic [1:0]        inIface,
  input  logic              varMode,
  input  logic [15:0]       cmtRecLen,
  input  logic [15:0]       cmtWireLen,
  input  logic [15:0]       cmtLoss,
  input  logic [15:0]       cmtCapEnd,
  input  logic              cmtTrunc,
  input  logic              cmtErr,
  input  logic [IDX_W-1:0]  emitIdx,
  output logic [63:0]       outData
);

  localparam int WIDX_W = ADDR_W - 3;

  logic [63:0] recMem [WORDS];
  logic [63:0] stampReg;
  logic [1:0]  ifaceReg;
  logic        modeReg;
  logic [15:0] recLenReg, wireLenReg, lossReg, capEndReg;
  logic        truncReg, errReg;

  logic [WIDX_W-1:0] wrWord;
  logic [2:0]        wrLane;
  logic [63:0]       stampSwap, hdrWord, memWord, dataWord;
  logic [7:0]        flagByte;

  assign wrWord = wrAddr[ADDR_W-1:3];
  assign wrLane = ~wrAddr[2:0];

  always_ff @(posedge clk) begin
    if (strobe.byteStore) recMem[wrWord][{wrLane, 3'b000} +: 8] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stampReg <= '0;
      ifaceReg <= '0;
      modeReg  <= 1'b0;
    end else if (strobe.frameStart) begin
      stampReg <= inStamp;
      ifaceReg <= inIface;
      modeReg  <= varMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recLenReg  <= '0;
      wireLenReg <= '0;
      lossReg    <= '0;
      capEndReg  <= '0;
      truncReg   <= 1'b0;
      errReg     <= 1'b0;
    end else if (strobe.recCommit) begin
      recLenReg  <= cmtRecLen;
      wireLenReg <= cmtWireLen;
      lossReg    <= cmtLoss;
      capEndReg  <= cmtCapEnd;
      truncReg   <= cmtTrunc;
      errReg     <= cmtErr;
    end
  end

  assign memWord  = recMem[emitIdx];
  assign flagByte = {3'b000, errReg, truncReg, modeReg, ifaceReg};
  assign hdrWord  = {REC_TYPE_ETH, flagByte, recLenReg, lossReg, wireLenReg};

  for (genvar ln = 0; ln < 8; ln++) begin : g_lane
    logic [15:0] bytePos;
    logic        keep;
    assign bytePos = 16'({emitIdx, 3'(ln)});
    assign keep    = (bytePos >= 16'(DATA_OFS)) && (bytePos < capEndReg);
    assign dataWord[63-8*ln -: 8]  = keep ? memWord[63-8*ln -: 8] : 8'h00;
    assign stampSwap[63-8*ln -: 8] = stampReg[8*ln +: 8];
  end

  always_comb begin
    if (emitIdx == '0)               outData = stampSwap;
    else if (emitIdx == IDX_W'(1))   outData = hdrWord;
    else                             outData = dataWord;
  end

endmodule

// File: rtl/caprec_formatter.sv
module caprec_formatter
  import caprec_pkg::*;
#(
  parameter int MIN_SNAP = 32,
  parameter int MAX_SNAP = 9600,
  parameter int SNAP_W   = $clog2(MAX_SNAP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inSof,
  input  logic              inEof,
  input  logic              inErr,
  input  logic [1:0]        inIface,
  input  logic [63:0]       inStamp,
  input  logic [SNAP_W-1:0] snapLen,
  input  logic              varMode,
  output logic [63:0]       outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outLast
);

  localparam int REC_MAX = MAX_SNAP + FIX_EXTRA;
  localparam int WORDS   = REC_MAX / 8;
  localparam int IDX_W   = $clog2(WORDS);
  localparam int ADDR_W  = $clog2(REC_MAX);

  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [IDX_W-1:0]  emitIdx;
  logic [15:0]       cmtRecLen, cmtWireLen, cmtLoss, cmtCapEnd;
  logic              cmtTrunc, cmtErr;

  caprec_ctrl #(
    .MIN_SNAP(MIN_SNAP), .MAX_SNAP(MAX_SNAP), .SNAP_W(SNAP_W),
    .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inErr(inErr), .snapLen(snapLen), .varMode(varMode), .outReady(outReady),
    .strobe(strobe), .wrAddr(wrAddr), .emitIdx(emitIdx),
    .cmtRecLen(cmtRecLen), .cmtWireLen(cmtWireLen), .cmtLoss(cmtLoss),
    .cmtCapEnd(cmtCapEnd), .cmtTrunc(cmtTrunc), .cmtErr(cmtErr),
    .outValid(outValid), .outLast(outLast)
  );

  caprec_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORDS(WORDS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrByte(inData),
    .inStamp(inStamp), .inIface(inIface), .varMode(varMode),
    .cmtRecLen(cmtRecLen), .cmtWireLen(cmtWireLen), .cmtLoss(cmtLoss),
    .cmtCapEnd(cmtCapEnd), .cmtTrunc(cmtTrunc), .cmtErr(cmtErr),
    .emitIdx(emitIdx), .outData(outData)
  );

endmodule

// File: rtl/caprec_formatter_chk.sv
module caprec_formatter_chk (
  input logic        clk,
  input logic        rstN,
  input logic [63:0] outData,
  input logic        outValid,
  input logic        outReady,
  input logic        outLast
);

  logic [15:0] beatIdx;
  logic [12:0] lenWords;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatIdx  <= '0;
      lenWords <= '0;
    end else if (outValid && outReady) begin
      beatIdx <= outLast ? 16'd0 : beatIdx + 16'd1;
      if (beatIdx == 16'd1) lenWords <= outData[47:35];
    end
  end

  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R6
  type_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatIdx == 16'd1 |-> outData[63:56] == 8'd2 && outData[34:32] == 3'd0);

  // R7
  flag_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatIdx == 16'd1 |-> outData[55:53] == 3'd0);

  // R4
  last_at_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> beatIdx >= 16'd2 && beatIdx + 16'd1 == {3'b000, lenWords});

endmodule

bind caprec_formatter caprec_formatter_chk u_chk (.*);

// File: tb/test_caprec_formatter.sv
module test_caprec_formatter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0, inErr = 1'b0;
  logic [7:0]  inData = '0;
  logic [1:0]  inIface = '0;
  logic [63:0] inStamp = '0;
  logic [13:0] snapLen = 14'd64;
  logic        varMode = 1'b1;
  logic [63:0] outData;
  logic        outValid, outLast;
  logic        outReady = 1'b1;

  always #2.5 clk = ~clk;

  caprec_formatter i_caprec_formatter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSof(inSof),
    .inEof(inEof), .inErr(inErr), .inIface(inIface), .inStamp(inStamp),
    .snapLen(snapLen), .varMode(varMode), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outLast(outLast)
  );

  int nChk = 0, nBad = 0;
  logic [63:0] got [0:1299];
  int gotN = 0, recDone = 0;

  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (gotN < 1300) got[gotN] = outData;
      gotN++;
      if (outLast) recDone++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  typedef struct packed {
    int      len;
    int      snap;
    bit      varM;
    bit [1:0] ifc;
    bit      err;
    int      req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{64,    128,   1'b1, 2'd0, 1'b0, 2},   // R2 short frame
    '{200,   96,    1'b1, 2'd1, 1'b0, 2},   // R2 truncated
    '{40,    64,    1'b0, 2'd2, 1'b0, 3},   // R3 padded
    '{300,   128,   1'b0, 2'd3, 1'b0, 3},   // R3 truncated
    '{100,   5,     1'b1, 2'd0, 1'b0, 1},   // R1 below minimum
    '{100,   77,    1'b0, 2'd1, 1'b0, 1},   // R1 unaligned
    '{50,    16000, 1'b0, 2'd2, 1'b0, 1},   // R1 above maximum
    '{33,    64,    1'b1, 2'd1, 1'b1, 7},   // R7 receive error
    '{1,     32,    1'b1, 2'd3, 1'b0, 8},   // R8 one byte frame
    '{9700,  9600,  1'b1, 2'd0, 1'b0, 11},  // R11 long frame
    '{64,    64,    1'b1, 2'd0, 1'b0, 2}    // R2 frame equal to snap
  };

  function automatic int effSnap(int p);
    int s;
    s = p;
    if (s < 32) s = 32;
    if (s > 9600) s = 9600;
    return s - (s % 8);
  endfunction

  function automatic int recLen(int len, int snapP, bit varM);
    int s, cap;
    s = effSnap(snapP);
    cap = (len < s) ? len : s;
    return varM ? ((cap + 18 + 7) / 8) * 8 : s + 24;
  endfunction

  function automatic logic [7:0] frameByte(int seed, int i);
    return 8'((seed + i * 13) & 255);
  endfunction

  function automatic logic [63:0] expWord(int w, int len, int seed, int snapP, bit varM,
                                          logic [1:0] ifc, bit err, logic [63:0] ts, int loss);
    logic [63:0] r;
    logic [7:0]  flg;
    logic [15:0] rl, wl, ls;
    int s, cap;
    s   = effSnap(snapP);
    cap = (len < s) ? len : s;
    rl  = 16'(recLen(len, snapP, varM));
    wl  = (len > 65535) ? 16'hFFFF : 16'(len);
    ls  = 16'(loss);
    flg = {3'b000, err, (len > s), varM, ifc};
    for (int j = 0; j < 8; j++) begin
      int k;
      logic [7:0] b;
      k = 8 * w + j;
      if (k < 8)       b = ts[8*k +: 8];
      else if (k == 8)  b = 8'd2;
      else if (k == 9)  b = flg;
      else if (k == 10) b = rl[15:8];
      else if (k == 11) b = rl[7:0];
      else if (k == 12) b = ls[15:8];
      else if (k == 13) b = ls[7:0];
      else if (k == 14) b = wl[15:8];
      else if (k == 15) b = wl[7:0];
      else if (k >= 18 && k < 18 + cap) b = frameByte(seed, k - 18);
      else b = 8'h00;
      r[63-8*j -: 8] = b;
    end
    return r;
  endfunction

  task automatic clearMon();
    gotN = 0;
    recDone = 0;
  endtask

  task automatic sendFrame(int len, int seed, int snapP, bit varM, logic [1:0] ifc,
                           bit err, logic [63:0] ts);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      inValid = 1'b1;
      inSof   = (i == 0);
      inEof   = (i == len - 1);
      inErr   = err && (i == len / 2);
      inData  = frameByte(seed, i);
      inStamp = (i == 0) ? ts : ~ts;
      inIface = (i == 0) ? ifc : ~ifc;
      snapLen = 14'(snapP);
      varMode = varM;
    end
    @(posedge clk); #1;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; inErr = 1'b0;
    snapLen = 14'd200;
  endtask

  task automatic checkRec(int req, int len, int seed, int snapP, bit varM, logic [1:0] ifc,
                          bit err, logic [63:0] ts, int loss);
    int t, words, bad, firstBad;
    logic [63:0] e, a;
    t = 0;
    while (recDone == 0 && t < 40000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk); #1;
    words = recLen(len, snapP, varM) / 8;
    nChk++;
    if (recDone != 1 || gotN != words) begin
      nBad++;
      $display("FAIL R%0d record word count: actual=%0d (records %0d) expected=%0d",
               req, gotN, recDone, words);
    end
    bad = 0; firstBad = -1; e = '0; a = '0;
    for (int w = 0; w < words && w < 1300; w++) begin
      logic [63:0] ew;
      ew = expWord(w, len, seed, snapP, varM, ifc, err, ts, loss);
      if (got[w] !== ew) begin
        if (bad == 0) begin firstBad = w; e = ew; a = got[w]; end
        bad++;
      end
    end
    nChk++;
    if (bad != 0) begin
      nBad++;
      $display("FAIL R%0d record content word %0d: actual=%h expected=%h (%0d bad words)",
               req, firstBad, a, e, bad);
    end
    clearMon();
  endtask

  initial begin
    logic [63:0] ts;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    nChk++;
    if (outValid !== 1'b0) begin
      nBad++; $display("FAIL R12 outValid after reset: actual=%b expected=0", outValid);
    end
    nChk++;
    if (outLast !== 1'b0) begin
      nBad++; $display("FAIL R4 outLast after reset: actual=%b expected=0", outLast);
    end

    // table of vectors: R1 R2 R3 R5 R6 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      ts = 64'h0123_4567_89AB_CD00 + 64'(v) * 64'h1111;
      clearMon();
      sendFrame(VECS[v].len, v * 31 + 5, VECS[v].snap, VECS[v].varM, VECS[v].ifc,
                VECS[v].err, ts);
      checkRec(VECS[v].req, VECS[v].len, v * 31 + 5, VECS[v].snap, VECS[v].varM,
               VECS[v].ifc, VECS[v].err, ts, 0);
    end

    // R9 R10: frames starting during a stalled record are dropped and counted
    clearMon();
    @(posedge clk); #1 outReady = 1'b0;
    sendFrame(40, 77, 64, 1'b1, 2'd1, 1'b0, 64'hAAAA_0000_1111_2222);
    repeat (2) @(posedge clk);
    for (int d = 0; d < 3; d++) sendFrame(10, 200 + d, 64, 1'b1, 2'd2, 1'b0, 64'h5);
    @(negedge clk);
    nChk++;  // R12 nothing accepted while not ready
    if (gotN != 0 || outValid !== 1'b1) begin
      nBad++; $display("FAIL R12 stall: actual beats=%0d valid=%b expected beats=0 valid=1",
                       gotN, outValid);
    end
    @(posedge clk); #1 outReady = 1'b1;
    checkRec(9, 40, 77, 64, 1'b1, 2'd1, 1'b0, 64'hAAAA_0000_1111_2222, 0);
    sendFrame(24, 91, 64, 1'b0, 2'd0, 1'b0, 64'h77);
    checkRec(10, 24, 91, 64, 1'b0, 2'd0, 1'b0, 64'h77, 3);
    sendFrame(24, 92, 64, 1'b1, 2'd0, 1'b0, 64'h78);
    checkRec(10, 24, 92, 64, 1'b1, 2'd0, 1'b0, 64'h78, 0);

    // R10 saturation of the loss count
    clearMon();
    @(posedge clk); #1 outReady = 1'b0;
    sendFrame(20, 13, 64, 1'b1, 2'd3, 1'b0, 64'h99);
    repeat (2) @(posedge clk);
    for (int d = 0; d < 65540; d++) begin
      @(posedge clk); #1;
      inValid = 1'b1; inSof = 1'b1; inEof = 1'b1; inData = 8'hEE;
    end
    @(posedge clk); #1;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    outReady = 1'b1;
    checkRec(10, 20, 13, 64, 1'b1, 2'd3, 1'b0, 64'h99, 0);
    sendFrame(30, 14, 64, 1'b1, 2'd0, 1'b0, 64'h9A);
    checkRec(10, 30, 14, 64, 1'b1, 2'd0, 1'b0, 64'h9A, 65535);
    sendFrame(30, 15, 64, 1'b1, 2'd0, 1'b0, 64'h9B);
    checkRec(10, 30, 15, 64, 1'b1, 2'd0, 1'b0, 64'h9B, 0);

    // R12 record intact under a toggling ready
    clearMon();
    sendFrame(90, 44, 64, 1'b0, 2'd2, 1'b0, 64'hFEDC_BA98_7654_3210);
    for (int c = 0; c < 40; c++) begin
      @(posedge clk); #1 outReady = (c % 3 != 0);
    end
    @(posedge clk); #1 outReady = 1'b1;
    checkRec(12, 90, 44, 64, 1'b0, 2'd2, 1'b0, 64'hFEDC_BA98_7654_3210, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule